// File: doc/BRIEF.md
# Decode-Aware Two-Stream Slot Merger

This block interleaves two separately compressed bitstreams into a single sequence of 8-bit storage words, each made of two 4-bit slots. It keeps a running estimate of how many bits each of the two downstream parallel decoders holds in its input buffer. From that estimate it decides, word by word, which stream supplies each slot. A decoder that is about to run dry gets both slots of the word, and the other decoder gets none. The goal is to keep both decoders busy when they read the stored words back in parallel.

Each stream source offers one chunk per handshake. A chunk is a group of up to four bits plus a length, and one chunk fills exactly one slot. A branch-block end marker closes the current block. It flushes any half-built word and restarts both buffer estimates from empty, because decoding restarts at every branch target.

Top module: `bsm_merger`

## Requirements
- R1: After reset, no word is valid, both buffer estimates are zero, and the first slot is owed to stream A (aReady=1, bReady=0).
- R2: If both estimates are below the decode threshold, or both are at or above it, stream A fills Slot1 (word[3:0]) and stream B fills Slot2 (word[7:4]).
- R3: If only stream B's estimate is at or above the threshold, stream A fills both slots of the word.
- R4: If only stream A's estimate is at or above the threshold, stream B fills both slots of the word.
- R5: A stream counts as ready when its estimate is at least the decode threshold SUFF_LEN = 5 bits, which is one flag bit plus the 4-bit raw field. Ownership is fixed from the estimates held at the start of the word.
- R6: When a complete word is emitted, each estimate drops by 5 if that stream was ready, and rises by the lengths of the chunks that stream placed in the word.
- R7: Slot bits at positions at or above the chunk length are zero. A length field above 4 counts as 4.
- R8: Only the owner of the current slot sees its ready signal high. While the owner is not valid, nothing is accepted and the slot position does not change.
- R9: wordValid pulses for one cycle, in the cycle after the clock edge that accepts the second slot.
- R10: When blockEnd is high, a half-built word is emitted in the next cycle with Slot2 zero. A chunk accepted at the same edge belongs to the ending block and is placed in the word.
- R11: At blockEnd, both estimates return to zero and the next slot is Slot1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| aValid | input | 1 | Stream A chunk offered |
| aData | input | 4 | Stream A chunk bits, LSB first |
| aLen | input | 3 | Stream A chunk length (0 to 4) |
| aReady | output | 1 | Stream A chunk accepted when valid |
| bValid | input | 1 | Stream B chunk offered |
| bData | input | 4 | Stream B chunk bits, LSB first |
| bLen | input | 3 | Stream B chunk length (0 to 4) |
| bReady | output | 1 | Stream B chunk accepted when valid |
| blockEnd | input | 1 | Branch-block end: flush and restart |
| wordValid | output | 1 | Storage word strobe |
| word | output | 8 | Storage word, Slot1 in [3:0], Slot2 in [7:4] |

## Verification
The slot handshake and the branch-block flush can fall on the same edge. The bench raises blockEnd at random, including while the slot owner is valid and while either slot is pending. In each case a model predicts whether the word is full or padded and whether a word appears at all. The bench also checks that the ready signals point at stream A in the cycle after the flush, whatever the estimates were before it.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} srcSel_e;

  typedef struct packed {
    logic    capture;   // owner chunk taken this edge
    srcSel_e src;       // which stream owns the current slot
    logic    firstSlot; // current slot is Slot1
    logic    emit;      // word leaves this edge
    logic    restart;   // branch-block end
  } strobe_t;
endpackage

// File: rtl/bsm_ctrl.sv
module bsm_ctrl
  import bsm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    aValid,
  input  logic    bValid,
  input  logic    blockEnd,
  input  logic    readyA,
  input  logic    readyB,
  output logic    aReady,
  output logic    bReady,
  output logic    slotPos,
  output strobe_t strobe
);
  srcSel_e owner;
  logic accept;

  // one decoder starving: the other one yields both slots
  always_comb begin
    if (readyA ^ readyB) owner = readyA ? SRC_B : SRC_A;
    else                 owner = slotPos ? SRC_B : SRC_A;
  end

  assign aReady = (owner == SRC_A);
  assign bReady = (owner == SRC_B);
  assign accept = (owner == SRC_A) ? aValid : bValid;

  always_comb begin
    strobe.capture   = accept;
    strobe.src       = owner;
    strobe.firstSlot = !slotPos;
    strobe.emit      = (accept && slotPos) || (blockEnd && (slotPos || accept));
    strobe.restart   = blockEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         slotPos <= 1'b0;
    else if (blockEnd) slotPos <= 1'b0;
    else if (accept)   slotPos <= !slotPos;
  end
endmodule

// File: rtl/bsm_dpath.sv
module bsm_dpath
  import bsm_pkg::*;
#(
  parameter int SLOT_W   = 4,
  parameter int SUFF_LEN = 5
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          strobe,
  input  logic [SLOT_W-1:0]                aData,
  input  logic [$clog2(SLOT_W+1)-1:0]      aLen,
  input  logic [SLOT_W-1:0]                bData,
  input  logic [$clog2(SLOT_W+1)-1:0]      bLen,
  output logic                             readyA,
  output logic                             readyB,
  output logic                             wordValid,
  output logic [2*SLOT_W-1:0]              word
);
  localparam int LEN_W = $clog2(SLOT_W + 1);
  localparam int LVL_W = $clog2(2 * SLOT_W + SUFF_LEN);
  localparam int EXT_W = LVL_W + 1;

  logic [LVL_W-1:0]  levA, levB;
  logic [SLOT_W-1:0] holdData, curData, curChunk;
  logic [LEN_W-1:0]  holdLen, rawLen, curLen;
  srcSel_e           holdSrc;
  logic [EXT_W-1:0]  addA, addB, nextA, nextB;

  assign curData = (strobe.src == SRC_A) ? aData : bData;
  assign rawLen  = (strobe.src == SRC_A) ? aLen  : bLen;
  assign curLen  = (rawLen > LEN_W'(SLOT_W)) ? LEN_W'(SLOT_W) : rawLen;

  // zero padding above the chunk length
  for (genvar i = 0; i < SLOT_W; i++) begin : g_pad
    assign curChunk[i] = curData[i] && (LEN_W'(i) < curLen);
  end

  assign readyA = levA >= LVL_W'(SUFF_LEN);
  assign readyB = levB >= LVL_W'(SUFF_LEN);

  always_comb begin
    addA  = (holdSrc == SRC_A ? EXT_W'(holdLen) : '0) + (strobe.src == SRC_A ? EXT_W'(curLen) : '0);
    addB  = (holdSrc == SRC_B ? EXT_W'(holdLen) : '0) + (strobe.src == SRC_B ? EXT_W'(curLen) : '0);
    nextA = EXT_W'(levA) + addA - (readyA ? EXT_W'(SUFF_LEN) : '0);
    nextB = EXT_W'(levB) + addB - (readyB ? EXT_W'(SUFF_LEN) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levA      <= '0;
      levB      <= '0;
      holdData  <= '0;
      holdLen   <= '0;
      holdSrc   <= SRC_A;
      wordValid <= 1'b0;
      word      <= '0;
    end else begin
      wordValid <= strobe.emit;
      if (strobe.capture && strobe.firstSlot) begin
        holdData <= curChunk;
        holdLen  <= curLen;
        holdSrc  <= strobe.src;
      end
      if (strobe.emit) begin
        if (strobe.firstSlot) word <= {{SLOT_W{1'b0}}, curChunk};
        else word <= {(strobe.capture ? curChunk : {SLOT_W{1'b0}}), holdData};
      end
      if (strobe.restart) begin
        levA <= '0;
        levB <= '0;
      end else if (strobe.emit) begin
        levA <= nextA[LVL_W-1:0];
        levB <= nextB[LVL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/bsm_merger.sv
module bsm_merger
  import bsm_pkg::*;
#(
  parameter int SLOT_W   = 4,
  parameter int SUFF_LEN = 5,
  localparam int LEN_W   = $clog2(SLOT_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                aValid,
  input  logic [SLOT_W-1:0]   aData,
  input  logic [LEN_W-1:0]    aLen,
  output logic                aReady,
  input  logic                bValid,
  input  logic [SLOT_W-1:0]   bData,
  input  logic [LEN_W-1:0]    bLen,
  output logic                bReady,
  input  logic                blockEnd,
  output logic                wordValid,
  output logic [2*SLOT_W-1:0] word
);
  strobe_t strobe;
  logic readyA, readyB, slotPos;

  bsm_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .aValid(aValid), .bValid(bValid), .blockEnd(blockEnd),
    .readyA(readyA), .readyB(readyB), .aReady(aReady), .bReady(bReady),
    .slotPos(slotPos), .strobe(strobe)
  );

  bsm_dpath #(.SLOT_W(SLOT_W), .SUFF_LEN(SUFF_LEN)) dpathI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .aData(aData), .aLen(aLen),
    .bData(bData), .bLen(bLen), .readyA(readyA), .readyB(readyB),
    .wordValid(wordValid), .word(word)
  );
endmodule

// File: rtl/bsm_merger_chk.sv
module bsm_merger_chk (
  input logic clk,
  input logic rstN,
  input logic aValid,
  input logic bValid,
  input logic aReady,
  input logic bReady,
  input logic blockEnd,
  input logic wordValid,
  input logic slotPos
);
  p_single_owner_r8: assert property (@(posedge clk) disable iff (!rstN)
    $countones({aReady, bReady}) == 1);

  p_hold_slot_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!blockEnd && !(aReady && aValid) && !(bReady && bValid)) |=> $stable(slotPos));

  p_word_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!blockEnd && (aValid && aReady || bValid && bReady) && slotPos) |=> wordValid);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!blockEnd && !(aValid && aReady) && !(bValid && bReady)) |=> !wordValid);

  p_restart_owner_r11: assert property (@(posedge clk) disable iff (!rstN)
    blockEnd |=> (aReady && !bReady && !slotPos));
endmodule

bind bsm_merger bsm_merger_chk chkI (
  .clk(clk), .rstN(rstN), .aValid(aValid), .bValid(bValid), .aReady(aReady),
  .bReady(bReady), .blockEnd(blockEnd), .wordValid(wordValid), .slotPos(slotPos)
);

// File: tb/bsm_merger_test.sv
module bsm_merger_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic aValid = 0, bValid = 0, blockEnd = 0;
  logic [3:0] aData = 0, bData = 0;
  logic [2:0] aLen = 0, bLen = 0;
  logic aReady, bReady, wordValid;
  logic [7:0] word;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  // model state
  int levA = 0, levB = 0, mPos = 0, hData = 0, hLen = 0, hSrc = 0;

  always #2.5 clk = !clk;

  bsm_merger uut (.*);

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int clampLen(input int l);
    return (l > 4) ? 4 : l;
  endfunction

  function automatic int padChunk(input int d, input int l); // R7
    return d & ((1 << clampLen(l)) - 1);
  endfunction

  // owner of the current slot: 0 = A, 1 = B (R2, R3, R4, R5)
  function automatic int ownerOf();
    bit rA = levA >= 5, rB = levB >= 5;
    if (rA != rB) return rA ? 1 : 0;
    return mPos;
  endfunction

  function automatic string caseTag();
    bit rA = levA >= 5, rB = levB >= 5;
    if (rA && !rB) return "R4";
    if (rB && !rA) return "R3";
    return "R2";
  endfunction

  // one cycle: drive, check readies, clock, check word, update model
  task automatic step(input bit av, input int ad, input int al,
                      input bit bv, input int bd, input int bl, input bit be);
    int own, acc, cd, cl, expV, expW;
    string tg;
    @(negedge clk);
    aValid = av; aData = 4'(ad); aLen = 3'(al);
    bValid = bv; bData = 4'(bd); bLen = 3'(bl); blockEnd = be;
    #1;
    own = ownerOf();
    tg = caseTag();
    check({tg, "/R8 aReady"}, aReady, own == 0);
    check({tg, "/R8 bReady"}, bReady, own == 1);
    acc = (own == 0) ? av : bv;
    cd  = (own == 0) ? padChunk(ad, al) : padChunk(bd, bl);
    cl  = (own == 0) ? clampLen(al) : clampLen(bl);
    expV = 0; expW = 0;
    if (acc && mPos == 1) begin
      expV = 1; expW = (cd << 4) | hData;
    end else if (be && mPos == 1) begin
      expV = 1; expW = hData; tg = "R10";
    end else if (be && acc) begin
      expV = 1; expW = cd; tg = "R10";
    end
    if (be) tg = "R10";
    @(posedge clk); #1;
    check({tg, "/R9 wordValid"}, wordValid, expV);
    if (expV) check({tg, "/R7 word"}, word, expW);
    // R6: estimate update on a full word
    if (acc && mPos == 1 && !be) begin
      int dA = 0, dB = 0;
      if (hSrc == 0) dA += hLen; else dB += hLen;
      if (own == 0) dA += cl; else dB += cl;
      if (levA >= 5) dA -= 5;
      if (levB >= 5) dB -= 5;
      levA += dA; levB += dB;
    end
    if (acc && mPos == 0) begin
      hData = cd; hLen = cl; hSrc = own;
    end
    if (be) begin // R11
      levA = 0; levB = 0; mPos = 0;
    end else if (acc) mPos = 1 - mPos;
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 wordValid", wordValid, 0);
    check("R1 aReady", aReady, 1);
    check("R1 bReady", bReady, 0);
    @(negedge clk); rstN = 1;
    // R2: neither ready, full chunks
    step(1, 4'hA, 4, 1, 4'h5, 4, 0);
    step(1, 4'hA, 4, 1, 4'h5, 4, 0);
    // R2: stall while owner idle (R8)
    step(0, 0, 0, 1, 4'h3, 4, 0);
    step(1, 4'hF, 2, 1, 4'hF, 7, 0); // R7 padding and clamp
    step(1, 4'hF, 2, 1, 4'hF, 7, 0);
    // R4: A fed heavily, B starved
    step(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 12; i++) step(1, i, 4, 1, i + 3, 1, 0);
    // R3: B fed heavily, A starved
    step(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 12; i++) step(1, i, 1, 1, 15 - i, 4, 0);
    // R10: flush on half word, flush with same-edge accept, flush when empty
    step(1, 4'h9, 3, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    step(1, 4'h6, 4, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    step(1, 4'h1, 4, 1, 4'h2, 4, 0);
    step(1, 4'h1, 4, 1, 4'h2, 4, 1);
    // random mix
    for (int i = 0; i < 4000; i++)
      step(($urandom % 10) < 7, $urandom % 16, $urandom % 8,
           ($urandom % 10) < 7, $urandom % 16, $urandom % 8,
           ($urandom % 20) == 0);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule